// File: doc/BRIEF.md
# Up/Down Counter with Compare-Reload and Capture Channels

The block is a 16-bit counter that moves one step per count strobe, up or down according to a direction input. Compare register 0 does two jobs. Counting up, it sets the interval: on the strobe taken while the count equals it, the counter returns to zero. Counting down, it holds the reload value: with reload enabled, a strobe taken at zero loads it. A second compare register and two channel registers raise their own one-cycle match pulses as the count passes them. Each channel register can work as a compare register or as a capture register. In capture mode it takes a snapshot of the counter on the chosen edge of an asynchronous trigger.

Software-style writes arrive on a write-enable, address and data port. The map is: 0 counter, 1 compare 0, 2 compare 1, 3 channel 0, 4 channel 1, 5 control. The counter side runs through a small action selector with the actions HOLD, LOAD, INC, CLEAR, DEC and RELOAD. Each trigger input has a two-flop synchronizer and then a level state machine with the states LVL_LOW and LVL_HIGH. Its transitions are ROSE (LVL_LOW to LVL_HIGH) and FELL (LVL_HIGH to LVL_LOW). A transition that matches the channel's edge polarity is a valid edge.

Top module: `updn_cmp_timer`

## Requirements
- R1: A synchronous active-high `rst` clears the counter, both compare registers, both channel registers and the control register, and forces every interrupt output low on the next cycle.
- R2: A write with `wr_en`=1 loads `wr_data` into the register at `wr_addr`. The map is 0 counter, 1 compare 0, 2 compare 1, 3 channel 0, 4 channel 1, 5 control. A counter write in the same cycle as a count strobe wins, and that strobe is dropped.
- R3: A strobe (`cnt_en`=1) with `cnt_dn`=0 adds one to the counter when the count differs from compare 0, and FFFFh wraps to 0000h.
- R4: A strobe with `cnt_dn`=0 while the count equals compare 0 clears the counter to 0000h and pulses `irq_match[0]`.
- R5: A strobe with `cnt_dn`=1 while the count equals compare 0 only decrements the counter and pulses `irq_match[0]`.
- R6: A strobe with `cnt_dn`=1 at count 0000h loads compare 0 when control bit 0 (reload enable) is 1, and wraps to FFFFh when it is 0.
- R7: A strobe taken while the count equals compare 1 pulses `irq_match[1]` and does not alter the counting.
- R8: Channel i raises `irq_match[2+i]` on a strobe taken while the count equals its register, only while control bit 1+i (capture mode) is 0.
- R9: In capture mode, a valid edge on `cap_trig[i]` copies the counter into channel i and pulses `irq_cap[i]`, three clocks after the trigger change is sampled. Control bit 3+i selects the edge: 0 rising, 1 falling. The other edge has no effect.
- R10: Without a strobe or a counter write the count holds, and every interrupt output is a pulse one system clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count strobe, one cycle per step |
| cnt_dn | input | 1 | Direction: 1 down, 0 up |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| cap_trig | input | 2 | Asynchronous capture triggers, one per channel |
| cnt_val | output | 16 | Current count |
| cc_val | output | 32 | Channel registers, channel 0 in the low half |
| irq_match | output | 4 | Match pulses: compare 0, compare 1, channel 0, channel 1 |
| irq_cap | output | 2 | Capture pulses, one per channel |

## Verification
The assertions take `cnt_en` to be a one-cycle strobe sampled on the system clock, and `cap_trig` to hold each level for at least three clocks so that the synchronizer sees every change. The capture-pulse property relies on that spacing. The stimulus changes inputs only on the falling clock edge. Triggers stay low through reset, and every trigger level is held for four or more cycles. Capture-mode trigger changes never coincide with a write to the same channel register.

// File: rtl/updn_cmp_pkg.sv
package updn_cmp_pkg;
    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_INC,
        ACT_CLEAR,
        ACT_DEC,
        ACT_RELOAD
    } cnt_act_e;

    typedef enum logic {
        LVL_LOW,
        LVL_HIGH
    } trig_lvl_e;
endpackage

// File: rtl/updn_count_core.sv
module updn_count_core
    import updn_cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         down,
    input  logic         reload_en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt
);
    cnt_act_e act;

    always_comb begin
        if (load)
            act = ACT_LOAD;
        else if (!step)
            act = ACT_HOLD;
        else if (!down)
            act = (cnt == limit) ? ACT_CLEAR : ACT_INC;
        else
            act = ((cnt == '0) && reload_en) ? ACT_RELOAD : ACT_DEC;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            unique case (act)
                ACT_HOLD:   cnt <= cnt;
                ACT_LOAD:   cnt <= load_val;
                ACT_INC:    cnt <= cnt + W'(1);
                ACT_CLEAR:  cnt <= '0;
                ACT_DEC:    cnt <= cnt - W'(1);
                ACT_RELOAD: cnt <= limit;
                default:    cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/updn_cmp_chan.sv
module updn_cmp_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         armed,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] ref_val,
    output logic         hit
);
    always_ff @(posedge clk) begin
        if (rst)
            hit <= 1'b0;
        else
            hit <= step && armed && (cnt == ref_val);
    end
endmodule

// File: rtl/updn_cap_chan.sv
module updn_cap_chan
    import updn_cmp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic fall_sel,
    input  logic cap_mode,
    output logic fire
);
    logic      sync1, sync2;
    trig_lvl_e lvl, lvl_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            lvl   <= LVL_LOW;
        end else begin
            sync1 <= trig;
            sync2 <= sync1;
            lvl   <= lvl_nx;
        end
    end

    always_comb begin
        lvl_nx = lvl;
        fire   = 1'b0;
        unique case (lvl)
            LVL_LOW: begin
                if (sync2) begin
                    lvl_nx = LVL_HIGH;
                    fire   = cap_mode && !fall_sel;
                end
            end
            LVL_HIGH: begin
                if (!sync2) begin
                    lvl_nx = LVL_LOW;
                    fire   = cap_mode && fall_sel;
                end
            end
            default: lvl_nx = LVL_LOW;
        endcase
    end
endmodule

// File: rtl/updn_cmp_timer.sv
module updn_cmp_timer #(
    parameter int W      = 16,
    parameter int NUM_CM = 2,
    parameter int NUM_CC = 2,
    localparam int NUM_REG = NUM_CM + NUM_CC + 2,
    localparam int ADDR_W  = $clog2(NUM_REG),
    localparam int CTRL_W  = 1 + 2 * NUM_CC,
    localparam int NUM_IRQ = NUM_CM + NUM_CC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cnt_en,
    input  logic                cnt_dn,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [W-1:0]        wr_data,
    input  logic [NUM_CC-1:0]   cap_trig,
    output logic [W-1:0]        cnt_val,
    output logic [NUM_CC*W-1:0] cc_val,
    output logic [NUM_IRQ-1:0]  irq_match,
    output logic [NUM_CC-1:0]   irq_cap
);
    localparam int CTRL_ADDR = NUM_CM + NUM_CC + 1;

    logic [W-1:0]      cm_q [NUM_CM];
    logic [W-1:0]      cc_q [NUM_CC];
    logic [CTRL_W-1:0] ctrl_q;
    logic              wr_cnt, step_eff, reload_en;
    logic [NUM_CC-1:0] cap_mode, fall_sel, cap_fire;

    assign wr_cnt    = wr_en && (wr_addr == ADDR_W'(0));
    assign step_eff  = cnt_en && !wr_cnt;
    assign reload_en = ctrl_q[0];
    assign cap_mode  = ctrl_q[NUM_CC:1];
    assign fall_sel  = ctrl_q[2*NUM_CC:NUM_CC+1];

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_en && (wr_addr == ADDR_W'(CTRL_ADDR)))
            ctrl_q <= wr_data[CTRL_W-1:0];
    end

    updn_count_core #(.W(W)) core_i (
        .clk       (clk),
        .rst       (rst),
        .step      (step_eff),
        .down      (cnt_dn),
        .reload_en (reload_en),
        .load      (wr_cnt),
        .load_val  (wr_data),
        .limit     (cm_q[0]),
        .cnt       (cnt_val)
    );

    for (genvar i = 0; i < NUM_CM; i++) begin : g_cm
        always_ff @(posedge clk) begin
            if (rst)
                cm_q[i] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(1 + i)))
                cm_q[i] <= wr_data;
        end

        updn_cmp_chan #(.W(W)) cmp_i (
            .clk     (clk),
            .rst     (rst),
            .step    (step_eff),
            .armed   (1'b1),
            .cnt     (cnt_val),
            .ref_val (cm_q[i]),
            .hit     (irq_match[i])
        );
    end

    for (genvar i = 0; i < NUM_CC; i++) begin : g_cc
        always_ff @(posedge clk) begin
            if (rst)
                cc_q[i] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(1 + NUM_CM + i)))
                cc_q[i] <= wr_data;
            else if (cap_fire[i])
                cc_q[i] <= cnt_val;
        end

        always_ff @(posedge clk) begin
            if (rst)
                irq_cap[i] <= 1'b0;
            else
                irq_cap[i] <= cap_fire[i];
        end

        updn_cap_chan cap_i (
            .clk      (clk),
            .rst      (rst),
            .trig     (cap_trig[i]),
            .fall_sel (fall_sel[i]),
            .cap_mode (cap_mode[i]),
            .fire     (cap_fire[i])
        );

        updn_cmp_chan #(.W(W)) ccmp_i (
            .clk     (clk),
            .rst     (rst),
            .step    (step_eff),
            .armed   (!cap_mode[i]),
            .cnt     (cnt_val),
            .ref_val (cc_q[i]),
            .hit     (irq_match[NUM_CM+i])
        );

        assign cc_val[i*W +: W] = cc_q[i];
    end
endmodule

// File: rtl/updn_cmp_timer_chk.sv
module updn_cmp_timer_chk #(
    parameter int W      = 16,
    parameter int NUM_CM = 2,
    parameter int NUM_CC = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cnt_en,
    input logic                     cnt_dn,
    input logic                     wr_cnt,
    input logic [W-1:0]             cnt_val,
    input logic [W-1:0]             cm0,
    input logic                     reload_en,
    input logic [NUM_CC-1:0]        cap_mode,
    input logic [NUM_CM+NUM_CC-1:0] irq_match,
    input logic [NUM_CC-1:0]        irq_cap
);
    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (cnt_val == '0) && (irq_match == '0) && (irq_cap == '0));

    // R3
    a_r3_up_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !cnt_dn && !wr_cnt && (cnt_val != cm0))
        |=> (cnt_val == $past(cnt_val) + W'(1)));

    // R4
    a_r4_up_clear: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !cnt_dn && !wr_cnt && (cnt_val == cm0))
        |=> ((cnt_val == '0) && irq_match[0]));

    // R5
    a_r5_down_pass: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && cnt_dn && !wr_cnt && (cnt_val == cm0) && (cnt_val != '0))
        |=> ((cnt_val == $past(cnt_val) - W'(1)) && irq_match[0]));

    // R6
    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && cnt_dn && !wr_cnt && (cnt_val == '0) && reload_en)
        |=> (cnt_val == $past(cm0)));

    // R10
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !wr_cnt) |=> ($stable(cnt_val) && (irq_match == '0)));

    for (genvar i = 0; i < NUM_CC; i++) begin : g_ch
        // R8
        a_r8_capture_silent: assert property (@(posedge clk) disable iff (rst)
            cap_mode[i] |=> !irq_match[NUM_CM+i]);
        // R10
        a_r10_cap_pulse: assert property (@(posedge clk) disable iff (rst)
            irq_cap[i] |=> !irq_cap[i]);
    end
endmodule

bind updn_cmp_timer updn_cmp_timer_chk #(
    .W(W), .NUM_CM(NUM_CM), .NUM_CC(NUM_CC)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (cnt_en),
    .cnt_dn    (cnt_dn),
    .wr_cnt    (wr_cnt),
    .cnt_val   (cnt_val),
    .cm0       (cm_q[0]),
    .reload_en (reload_en),
    .cap_mode  (cap_mode),
    .irq_match (irq_match),
    .irq_cap   (irq_cap)
);

// File: tb/updn_cmp_timer_tb_top.sv
`timescale 1ns/1ps
module updn_cmp_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0, cnt_dn = 1'b0, wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  cap_trig = '0;
    logic [15:0] cnt_val;
    logic [31:0] cc_val;
    logic [3:0]  irq_match;
    logic [1:0]  irq_cap;

    int n_chk = 0, n_fail = 0;
    bit started = 0, done = 0;

    always #4 clk = ~clk;

    updn_cmp_timer dut_i (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_dn(cnt_dn),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cap_trig(cap_trig), .cnt_val(cnt_val), .cc_val(cc_val),
        .irq_match(irq_match), .irq_cap(irq_cap)
    );

    // behavioural reference
    int  m_cnt, m_cm[2], m_cc[2], m_ctrl;
    bit  m_irqm[4], m_irqc[2];
    bit  trig_q0[$], trig_q1[$];
    bit  seen_lvl[2];

    function automatic bit delayed_trig(int ch);
        if (ch == 0) return (trig_q0.size() >= 2) ? trig_q0[trig_q0.size()-2] : 1'b0;
        else         return (trig_q1.size() >= 2) ? trig_q1[trig_q1.size()-2] : 1'b0;
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_cnt = 0; m_cm = '{0, 0}; m_cc = '{0, 0}; m_ctrl = 0;
            m_irqm = '{0, 0, 0, 0}; m_irqc = '{0, 0};
            trig_q0.delete(); trig_q1.delete(); seen_lvl = '{0, 0};
        end else begin
            bit wr_c, stp, fire[2], cmode, fsel, lvl;
            int nxt, ref_v;
            wr_c = wr_en && wr_addr == 0;
            stp  = cnt_en && !wr_c;
            for (int i = 0; i < 4; i++) begin
                ref_v = (i < 2) ? m_cm[i] : m_cc[i-2];
                m_irqm[i] = stp && (m_cnt == ref_v) && (i < 2 || !m_ctrl[1 + (i-2)]);
            end
            for (int c = 0; c < 2; c++) begin
                cmode = m_ctrl[1+c]; fsel = m_ctrl[3+c];
                lvl = delayed_trig(c);
                fire[c] = cmode && (lvl != seen_lvl[c]) && (lvl == !fsel);
                seen_lvl[c] = lvl;
            end
            if (wr_c) nxt = wr_data;
            else if (!stp) nxt = m_cnt;
            else if (!cnt_dn) nxt = (m_cnt == m_cm[0]) ? 0 : (m_cnt + 1) % 65536;
            else if (m_cnt == 0 && m_ctrl[0]) nxt = m_cm[0];
            else nxt = (m_cnt + 65535) % 65536;
            for (int c = 0; c < 2; c++) begin
                if (wr_en && wr_addr == 3 + c) m_cc[c] = wr_data;
                else if (fire[c]) m_cc[c] = m_cnt;
                m_irqc[c] = fire[c];
            end
            if (wr_en && wr_addr == 1) m_cm[0] = wr_data;
            if (wr_en && wr_addr == 2) m_cm[1] = wr_data;
            if (wr_en && wr_addr == 5) m_ctrl = wr_data[4:0];
            m_cnt = nxt;
            trig_q0.push_back(cap_trig[0]);
            trig_q1.push_back(cap_trig[1]);
            if (trig_q0.size() > 4) void'(trig_q0.pop_front());
            if (trig_q1.size() > 4) void'(trig_q1.pop_front());
        end
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R1..R10)
    always @(negedge clk) begin
        if (started && !done) begin
            check("model cnt R3 R4 R5 R6", int'(cnt_val), m_cnt);
            check("model irq_match R4 R7 R8", int'(irq_match),
                  {m_irqm[3], m_irqm[2], m_irqm[1], m_irqm[0]});
            check("model irq_cap R9", int'(irq_cap), {m_irqc[1], m_irqc[0]});
            check("model cc R2 R9", int'(cc_val), {m_cc[1][15:0], m_cc[0][15:0]});
        end
    end

    task automatic wr(int a, int d);
        wr_en = 1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic strobe(bit dn);
        cnt_en = 1; cnt_dn = dn;
        @(negedge clk);
        cnt_en = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        idle(3);
        rst = 0;
        check("R1 counter after reset", int'(cnt_val), 0);
        check("R1 irq after reset", int'({irq_match, irq_cap}), 0);
        check("R1 cc after reset", int'(cc_val), 0);

        wr(1, 16'h0005); wr(0, 16'h0003);
        check("R2 counter write", int'(cnt_val), 16'h0003);
        strobe(0); check("R3 up step", int'(cnt_val), 16'h0004);
        strobe(0); strobe(0);
        check("R4 clear at compare 0", int'(cnt_val), 0);
        check("R4 irq_match0 pulse", int'(irq_match[0]), 1);
        idle(2);
        check("R10 hold without strobe", int'(cnt_val), 0);
        check("R10 pulse gone", int'(irq_match), 0);

        wr(0, 16'h0007); strobe(1); strobe(1);
        check("R5 no match yet", int'(irq_match[0]), 0);
        strobe(1);
        check("R5 down pass value", int'(cnt_val), 16'h0004);
        check("R5 irq_match0 on down", int'(irq_match[0]), 1);

        wr(5, 16'h0001); wr(0, 16'h0001); strobe(1); strobe(1);
        check("R6 reload from compare 0", int'(cnt_val), 16'h0005);
        wr(5, 16'h0000); wr(0, 16'h0000); strobe(1);
        check("R6 wrap to FFFF", int'(cnt_val), 16'hFFFF);

        wr(1, 16'h1000); wr(0, 16'hFFFF); strobe(0);
        check("R3 wrap to 0000", int'(cnt_val), 0);

        wr_en = 1; wr_addr = 3'd0; wr_data = 16'h0100; cnt_en = 1; cnt_dn = 0;
        @(negedge clk);
        wr_en = 0; cnt_en = 0;
        check("R2 write beats strobe", int'(cnt_val), 16'h0100);

        wr(2, 16'h0101); strobe(0);
        check("R7 not yet", int'(irq_match[1]), 0);
        strobe(0);
        check("R7 irq_match1", int'(irq_match[1]), 1);
        check("R7 count unaffected", int'(cnt_val), 16'h0102);

        wr(3, 16'h0045); wr(0, 16'h0044); strobe(0); strobe(0);
        check("R8 compare-mode match", int'(irq_match[2]), 1);
        wr(5, 16'h0002); wr(0, 16'h0045); strobe(0);
        check("R8 capture mode silent", int'(irq_match[2]), 0);

        wr(5, 16'h0016); wr(0, 16'h0040);
        cap_trig[0] = 1; idle(2);
        check("R9 no capture before sync", int'(irq_cap), 0);
        idle(1);
        check("R9 rising capture value", int'(cc_val[15:0]), 16'h0040);
        check("R9 capture pulse", int'(irq_cap[0]), 1);
        cap_trig[1] = 1; idle(5);
        check("R9 wrong edge ignored", int'(cc_val[31:16]), 0);
        wr(0, 16'h0077); cap_trig[1] = 0; idle(3);
        check("R9 falling capture value", int'(cc_val[31:16]), 16'h0077);
        check("R9 falling capture pulse", int'(irq_cap[1]), 1);
        cap_trig[0] = 0; idle(5);

        // mixed traffic, checked by the per-cycle model
        for (int k = 0; k < 600; k++) begin
            int r;
            r = int'($urandom_range(0, 15));
            cnt_en = (r < 10); cnt_dn = r[0];
            wr_en = 0;
            if (r == 15) begin
                wr_en = 1;
                wr_addr = 3'($urandom_range(0, 5));
                wr_data = (wr_addr == 3'd0 || wr_addr == 3'd1)
                          ? 16'($urandom_range(0, 12)) : 16'($urandom_range(0, 31));
                if (wr_addr == 3'd3 || wr_addr == 3'd4) wr_en = 0;
            end
            if (k % 8 == 0) cap_trig = 2'($urandom_range(0, 3));
            @(negedge clk);
        end
        cnt_en = 0; wr_en = 0;
        idle(4);
        summary();
    end
endmodule